// File: doc/BRIEF.md
# Register-Mapped Byte EEPROM Controller

This block gives a CPU access to a small nonvolatile byte array through four narrow registers on a plain register bus. A control register starts reads and writes and shows their state, a key register arms writes, a data register holds the byte moving in or out, and an address register selects the location. The array itself never appears in the register space. Inside the block the array is a register array; it models the storage, not the cell physics.

A read costs one clock. A write is timed by an internal counter: the target byte is erased when the write starts and takes the new value when the count runs out. Completion raises an interrupt flag, which only software clears. Writes are guarded twice: an enable bit must already be set, and the two key bytes must have been written just before the start request. A warm reset that hits a write in progress aborts it. It also leaves a sticky error bit set, and a power-on reset is the only reset that clears that bit.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After power-on reset (`por_ni` low) the control, data and address registers read 0x00 and `done_irq_o` is 0.
- R2: Register select `bus_addr_i`: 0 control, 1 key, 2 data, 3 address. The data and address registers read back the last value written to them. The key register always reads 0x00. `bus_rdata_o` is 0x00 whenever `bus_rd_i` is low.
- R3: The control register reads {4'b0, ERR(bit3), EN(bit2), WR(bit1), RD(bit0)}. Bits 7..4 always read 0. A control write loads EN from bit2 every time, busy or not.
- R4: A control write with bit0 set while the block is idle makes RD read 1 after that edge. At the next edge the data register takes the byte at the current address and RD returns to 0.
- R5: Writing 0 to WR while a write is running leaves WR at 1. Only completion or a reset clears it.
- R6: A control write with bit1 set starts a write only if EN was already 1 and the two register writes just before it were 0x55 to the key register and then 0xAA to the key register. Any other register write in between discards the key sequence. A refused request leaves WR at 0, the array untouched and the flag unchanged.
- R7: WR reads 1 for WRITE_CYCLES clocks after the accepted start edge. At the WRITE_CYCLES-th edge after it, the array byte takes the data register value and WR returns to 0.
- R8: The start edge of a write sets the target byte to 0xFF (erased).
- R9: While a write runs, writes to the data or address registers and new RD or WR requests have no effect.
- R10: `done_irq_o` rises at the completion edge and stays high until an edge with `irq_clr_i` high. If completion and clear meet at the same edge, the flag ends up set.
- R11: A warm reset (`rst_ni` low) clears data, address, EN, RD and any running write, and leaves the erased byte in place. It sets ERR if a write was running. ERR and the interrupt flag survive a warm reset. Power-on reset clears ERR.
- R12: A control write with bit3 at 0 clears ERR. A control write with bit3 at 1 never sets ERR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, synchronous |
| rst_ni | input | 1 | Warm reset, active low, synchronous |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the register state |
| done_irq_o | output | 1 | Write-complete interrupt flag |
| irq_clr_i | input | 1 | Clears the interrupt flag |

## Verification
Register reads are combinational, so a register write shows up on a read in the same low clock phase right after the edge that takes it. The loaded data byte appears one edge after the read request. WR, the array update and the interrupt flag change exactly WRITE_CYCLES edges after the start edge. The bench drives each bus operation on a falling edge and counts falling edges from the start request. It samples one cycle before and at the completion edge, and samples reads through the read strobe 1 time unit after the falling edge.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_KEY  = 2'd1,
      REG_DATA = 2'd2,
      REG_ADDR = 2'd3
   } nvb_reg_e;

   typedef enum logic [1:0] {
      KS_IDLE,
      KS_HALF,
      KS_ARMED
   } nvb_key_e;

   localparam int CB_RD  = 0;
   localparam int CB_WR  = 1;
   localparam int CB_EN  = 2;
   localparam int CB_ERR = 3;
   localparam int CTRL_BITS = 4;

endpackage

// File: rtl/nvb_keyseq.sv
module nvb_keyseq
   import nvb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY1 = 8'h55,
   parameter logic [DATA_W-1:0] KEY2 = 8'hAA
) (
   input  logic              clk_i,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic              is_key_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              armed_o
);

   nvb_key_e state_q;

   initial begin : p_param_chk
      assert (KEY1 != KEY2) else $fatal(1, "key bytes must differ");
   end

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         state_q <= KS_IDLE;
      end else if (wr_i) begin
         if (is_key_i && wdata_i == KEY1)
            state_q <= KS_HALF;
         else if (is_key_i && state_q == KS_HALF && wdata_i == KEY2)
            state_q <= KS_ARMED;
         else
            state_q <= KS_IDLE;
      end
   end

   assign armed_o = (state_q == KS_ARMED);

   // R6
   armed_from_half_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      $rose(armed_o) |-> $past(wr_i && is_key_i && state_q == KS_HALF));

endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic start_i,
   output logic busy_o,
   output logic last_o
);

   localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   initial begin : p_param_chk
      assert (CYCLES >= 2) else $fatal(1, "CYCLES must be at least 2");
   end

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0)
            busy_q <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign last_o = busy_q && (cnt_q == '0);

   // R7
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
      busy_q && (cnt_q != '0) |=> busy_q);

endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   initial begin : p_param_chk
      assert (ADDR_W >= 1 && ADDR_W <= 10) else $fatal(1, "ADDR_W out of range");
   end

   always_ff @(posedge clk_i) begin
      if (we_i)
         cells[waddr_i] <= wdata_i;
   end

   assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
   import nvb_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int WRITE_CYCLES = 64,
   parameter bit ERASE_FIRST  = 1'b1,
   parameter logic [DATA_W-1:0] ERASED_VAL = '1,
   parameter logic [DATA_W-1:0] KEY1 = 8'h55,
   parameter logic [DATA_W-1:0] KEY2 = 8'hAA
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              rst_ni,
   input  logic [1:0]        bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              done_irq_o,
   input  logic              irq_clr_i
);

   logic              clr_all;
   logic              sel_ctrl, sel_key, sel_data, sel_addr;
   logic              armed, busy, last;
   logic              wr_go, rd_go;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q, en_q, err_q, irq_q;
   logic              arr_we;
   logic [DATA_W-1:0] arr_wdata, arr_rdata;

   initial begin : p_param_chk
      assert (ADDR_W <= DATA_W) else $fatal(1, "address must fit the data register");
      assert (DATA_W >= CTRL_BITS) else $fatal(1, "data width too small for control bits");
   end

   assign clr_all  = !por_ni || !rst_ni;
   assign sel_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
   assign sel_key  = bus_wr_i && (bus_addr_i == REG_KEY);
   assign sel_data = bus_wr_i && (bus_addr_i == REG_DATA);
   assign sel_addr = bus_wr_i && (bus_addr_i == REG_ADDR);

   assign wr_go = sel_ctrl && bus_wdata_i[CB_WR] && en_q && armed && !busy;
   assign rd_go = sel_ctrl && bus_wdata_i[CB_RD] && !busy && !wr_go;

   nvb_keyseq #(
      .DATA_W (DATA_W),
      .KEY1   (KEY1),
      .KEY2   (KEY2)
   ) u_keyseq (
      .clk_i    (clk_i),
      .clr_i    (clr_all),
      .wr_i     (bus_wr_i),
      .is_key_i (sel_key),
      .wdata_i  (bus_wdata_i),
      .armed_o  (armed)
   );

   nvb_timer #(
      .CYCLES (WRITE_CYCLES)
   ) u_timer (
      .clk_i   (clk_i),
      .clr_i   (clr_all),
      .start_i (wr_go),
      .busy_o  (busy),
      .last_o  (last)
   );

   generate
      if (ERASE_FIRST) begin : g_erase
         assign arr_we    = !clr_all && (wr_go || last);
         assign arr_wdata = last ? data_q : ERASED_VAL;
      end else begin : g_direct
         assign arr_we    = !clr_all && last;
         assign arr_wdata = data_q;
      end
   endgenerate

   nvb_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_array (
      .clk_i   (clk_i),
      .we_i    (arr_we),
      .waddr_i (addr_q),
      .wdata_i (arr_wdata),
      .raddr_i (addr_q),
      .rdata_o (arr_rdata)
   );

   always_ff @(posedge clk_i) begin
      if (!por_ni) begin
         data_q <= '0;
         addr_q <= '0;
         rd_q   <= 1'b0;
         en_q   <= 1'b0;
         err_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else if (!rst_ni) begin
         data_q <= '0;
         addr_q <= '0;
         rd_q   <= 1'b0;
         en_q   <= 1'b0;
         err_q  <= err_q || busy;
      end else begin
         if (sel_ctrl) begin
            en_q <= bus_wdata_i[CB_EN];
            if (!bus_wdata_i[CB_ERR])
               err_q <= 1'b0;
         end
         rd_q <= rd_go;
         if (rd_q)
            data_q <= arr_rdata;
         else if (sel_data && !busy)
            data_q <= bus_wdata_i;
         if (sel_addr && !busy)
            addr_q <= bus_wdata_i[ADDR_W-1:0];
         if (last)
            irq_q <= 1'b1;
         else if (irq_clr_i)
            irq_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_rd_i) begin
         case (bus_addr_i)
            REG_CTRL: begin
               bus_rdata_o[CB_RD]  = rd_q;
               bus_rdata_o[CB_WR]  = busy;
               bus_rdata_o[CB_EN]  = en_q;
               bus_rdata_o[CB_ERR] = err_q;
            end
            REG_DATA: bus_rdata_o = data_q;
            REG_ADDR: bus_rdata_o = DATA_W'(addr_q);
            default:  bus_rdata_o = '0;
         endcase
      end
   end

   assign done_irq_o = irq_q;

   // R6
   start_keyed_chk: assert property (@(posedge clk_i) disable iff (clr_all)
      $rose(busy) |-> $past(sel_ctrl && bus_wdata_i[CB_WR] && en_q && armed));

   // R9
   frozen_busy_chk: assert property (@(posedge clk_i) disable iff (clr_all)
      busy |=> $stable(addr_q) && $stable(data_q));

   // R10
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (clr_all)
      $rose(done_irq_o) |-> $past(last));

   // R4
   rd_pulse_chk: assert property (@(posedge clk_i) disable iff (clr_all)
      rd_q |=> !rd_q);

endmodule

// File: tb/tb_nvbyte_ctrl.sv
module tb_nvbyte_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WC = 16;
   localparam logic [1:0] A_CTRL = 2'd0, A_KEY = 2'd1, A_DATA = 2'd2, A_ADDR = 2'd3;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b1;
   logic [1:0] baddr = '0;
   logic       bwr = 1'b0, brd = 1'b0, iclr = 1'b0;
   logic [7:0] bwdata = '0;
   logic [7:0] brdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [7:0] shadow [256];
   bit         known  [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   nvbyte_ctrl #(.WRITE_CYCLES(WC)) dut (
      .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
      .bus_addr_i(baddr), .bus_wr_i(bwr), .bus_rd_i(brd),
      .bus_wdata_i(bwdata), .bus_rdata_o(brdata),
      .done_irq_o(irq), .irq_clr_i(iclr)
   );

   function automatic logic [7:0] ctrl_exp(bit rd, bit wr, bit en, bit err);
      return {4'b0000, err, en, wr, rd};
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bw(logic [1:0] a, logic [7:0] d);
      baddr = a; bwdata = d; bwr = 1'b1;
      @(negedge clk);
      bwr = 1'b0;
   endtask

   task automatic br(logic [1:0] a, output logic [7:0] d);
      baddr = a; brd = 1'b1;
      #1;
      d = brdata;
      brd = 1'b0;
   endtask

   task automatic chk_reg(string tag, logic [1:0] a, logic [7:0] exp);
      logic [7:0] v;
      br(a, v);
      check(tag, v, exp);
   endtask

   task automatic start_write(logic [7:0] a, logic [7:0] d);
      bw(A_ADDR, a); bw(A_DATA, d); bw(A_CTRL, 8'h04);
      bw(A_KEY, 8'h55); bw(A_KEY, 8'hAA); bw(A_CTRL, 8'h06);
   endtask

   task automatic read_array(logic [7:0] a, bit keep_err, output logic [7:0] d);
      bw(A_ADDR, a);
      bw(A_CTRL, keep_err ? 8'h09 : 8'h01);
      @(negedge clk);
      br(A_DATA, d);
   endtask

   task automatic pulse_clr();
      iclr = 1'b1; @(negedge clk); iclr = 1'b0;
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: got hang expected completion");
         report();
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'd2718));
      for (int i = 0; i < 256; i++) known[i] = 0;

      repeat (3) @(negedge clk);
      por_n = 1'b1;
      // R1 reset state
      chk_reg("R1 ctrl", A_CTRL, 8'h00);
      chk_reg("R1 data", A_DATA, 8'h00);
      chk_reg("R1 addr", A_ADDR, 8'h00);
      check("R1 irq", {7'b0, irq}, 8'h00);

      // R2 register map and readback
      bw(A_DATA, 8'hA5); bw(A_ADDR, 8'h3C); bw(A_KEY, 8'h55);
      chk_reg("R2 data", A_DATA, 8'hA5);
      chk_reg("R2 addr", A_ADDR, 8'h3C);
      chk_reg("R2 key reads zero", A_KEY, 8'h00);
      #1; check("R2 no strobe", brdata, 8'h00);

      // R3 control layout
      bw(A_CTRL, 8'hF4);
      chk_reg("R3 upper bits zero", A_CTRL, ctrl_exp(0, 0, 1, 0));
      bw(A_CTRL, 8'h00);
      chk_reg("R3 enable cleared", A_CTRL, 8'h00);

      // R7 write timing
      start_write(8'h10, 8'h5A);
      chk_reg("R7 wr set", A_CTRL, ctrl_exp(0, 1, 1, 0));
      check("R7 irq low during write", {7'b0, irq}, 8'h00);
      repeat (WC - 1) @(negedge clk);
      chk_reg("R7 still busy one before end", A_CTRL, ctrl_exp(0, 1, 1, 0));
      @(negedge clk);
      chk_reg("R7 wr cleared at end", A_CTRL, ctrl_exp(0, 0, 1, 0));
      check("R10 irq at completion", {7'b0, irq}, 8'h01);
      shadow[8'h10] = 8'h5A; known[8'h10] = 1;
      repeat (4) @(negedge clk);
      check("R10 irq holds", {7'b0, irq}, 8'h01);
      pulse_clr();
      check("R10 irq cleared", {7'b0, irq}, 8'h00);

      // R4 read timing
      bw(A_ADDR, 8'h10);
      bw(A_CTRL, 8'h05);
      chk_reg("R4 rd pending", A_CTRL, ctrl_exp(1, 0, 1, 0));
      @(negedge clk);
      chk_reg("R4 data loaded", A_DATA, 8'h5A);
      chk_reg("R4 rd cleared", A_CTRL, ctrl_exp(0, 0, 1, 0));

      // R9 and R5: requests while busy
      start_write(8'h20, 8'h77);
      bw(A_DATA, 8'h12);
      bw(A_ADDR, 8'h34);
      bw(A_CTRL, 8'h04);
      chk_reg("R5 wr not cleared by zero", A_CTRL, ctrl_exp(0, 1, 1, 0));
      bw(A_CTRL, 8'h05);
      chk_reg("R9 rd ignored while busy", A_CTRL, ctrl_exp(0, 1, 1, 0));
      chk_reg("R9 data frozen", A_DATA, 8'h77);
      chk_reg("R9 addr frozen", A_ADDR, 8'h20);
      repeat (WC) @(negedge clk);
      chk_reg("R9 write finished", A_CTRL, ctrl_exp(0, 0, 1, 0));
      shadow[8'h20] = 8'h77; known[8'h20] = 1;
      pulse_clr();
      read_array(8'h20, 0, v);
      check("R9 stored value", v, 8'h77);

      // R10 set wins over clear
      start_write(8'h21, 8'h33);
      iclr = 1'b1;
      repeat (WC) @(negedge clk);
      check("R10 set wins", {7'b0, irq}, 8'h01);
      iclr = 1'b0;
      @(negedge clk);
      check("R10 stays after tie", {7'b0, irq}, 8'h01);
      pulse_clr();
      shadow[8'h21] = 8'h33; known[8'h21] = 1;

      // R6 refused starts
      bw(A_CTRL, 8'h00); bw(A_ADDR, 8'h10); bw(A_DATA, 8'hC3);
      bw(A_KEY, 8'h55); bw(A_KEY, 8'hAA); bw(A_CTRL, 8'h02);
      chk_reg("R6 no enable", A_CTRL, ctrl_exp(0, 0, 0, 0));
      bw(A_CTRL, 8'h04);
      bw(A_KEY, 8'h55); bw(A_DATA, 8'hC3); bw(A_KEY, 8'hAA); bw(A_CTRL, 8'h06);
      chk_reg("R6 broken sequence", A_CTRL, ctrl_exp(0, 0, 1, 0));
      bw(A_KEY, 8'hAA); bw(A_KEY, 8'h55); bw(A_CTRL, 8'h06);
      chk_reg("R6 wrong order", A_CTRL, ctrl_exp(0, 0, 1, 0));
      bw(A_KEY, 8'h55); bw(A_KEY, 8'hAA); bw(A_CTRL, 8'h04); bw(A_CTRL, 8'h06);
      chk_reg("R6 sequence consumed", A_CTRL, ctrl_exp(0, 0, 1, 0));
      repeat (WC + 2) @(negedge clk);
      check("R6 no irq", {7'b0, irq}, 8'h00);
      read_array(8'h10, 0, v);
      check("R6 array untouched", v, 8'h5A);
      bw(A_CTRL, 8'h04);
      bw(A_KEY, 8'h55); bw(A_KEY, 8'h55); bw(A_KEY, 8'hAA); bw(A_CTRL, 8'h06);
      chk_reg("R6 repeated first key accepted", A_CTRL, ctrl_exp(0, 1, 1, 0));
      repeat (WC) @(negedge clk);
      pulse_clr();
      shadow[8'h10] = 8'hC3;

      // random writes mixed with broken attempts
      for (int it = 0; it < 40; it++) begin
         logic [7:0] ra, rd_;
         bit brk;
         ra = 8'($urandom); rd_ = 8'($urandom);
         brk = ($urandom % 4) == 0;
         bw(A_ADDR, ra); bw(A_DATA, rd_); bw(A_CTRL, 8'h04);
         bw(A_KEY, 8'h55);
         if (brk) bw(A_ADDR, ra);
         bw(A_KEY, 8'hAA); bw(A_CTRL, 8'h06);
         if (brk) begin
            chk_reg("R6 random refused", A_CTRL, ctrl_exp(0, 0, 1, 0));
         end else begin
            repeat (WC) @(negedge clk);
            chk_reg("R7 random done", A_CTRL, ctrl_exp(0, 0, 1, 0));
            check("R10 random irq", {7'b0, irq}, 8'h01);
            pulse_clr();
            shadow[ra] = rd_; known[ra] = 1;
         end
         if (known[ra]) begin
            read_array(ra, 0, v);
            check("R4 random readback", v, shadow[ra]);
         end
      end

      // R11 and R8: warm reset during a write
      start_write(8'h40, 8'h11);
      repeat (WC) @(negedge clk);
      pulse_clr();
      start_write(8'h40, 8'h9C);
      repeat (3) @(negedge clk);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      chk_reg("R11 err set", A_CTRL, ctrl_exp(0, 0, 0, 1));
      chk_reg("R11 data cleared", A_DATA, 8'h00);
      chk_reg("R11 addr cleared", A_ADDR, 8'h00);
      repeat (WC + 2) @(negedge clk);
      check("R11 no completion", {7'b0, irq}, 8'h00);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      chk_reg("R11 err sticky", A_CTRL, ctrl_exp(0, 0, 0, 1));
      bw(A_CTRL, 8'h08);
      chk_reg("R12 one keeps err", A_CTRL, ctrl_exp(0, 0, 0, 1));
      read_array(8'h40, 1, v);
      check("R8 erased byte", v, 8'hFF);
      bw(A_CTRL, 8'h00);
      chk_reg("R12 zero clears err", A_CTRL, 8'h00);
      bw(A_CTRL, 8'h08);
      chk_reg("R12 one does not set", A_CTRL, 8'h00);
      start_write(8'h40, 8'h9C);
      repeat (WC) @(negedge clk);
      pulse_clr();
      read_array(8'h40, 0, v);
      check("R11 retry stored", v, 8'h9C);

      // R11 power-on reset clears err
      start_write(8'h41, 8'h01);
      @(negedge clk);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      chk_reg("R11 err before por", A_CTRL, ctrl_exp(0, 0, 0, 1));
      por_n = 1'b0; @(negedge clk); por_n = 1'b1;
      chk_reg("R11 por clears err", A_CTRL, 8'h00);

      finished = 1;
      report();
      $finish;
   end

endmodule